// File: doc/BRIEF.md
# Program Status Polling Responder

This block sits between the memory array's read port and the host read bus. While a program cycle (or the dummy busy period that follows a rejected write) is running, it replaces the array data with a status byte. Bit 7 carries the inverse of bit 7 of the last loaded byte. Bit 6 is a toggle that flips on every read. The remaining bits echo the last loaded byte. When the busy flag drops, every read returns the true array data and the toggle freezes.

Host software can read at any moment during the cycle. It can compare bit 7 against the value it wrote, or it can watch bit 6 across two successive reads. Either method shows whether the cycle has finished.

The write sequencer supplies the busy flag and the last loaded byte and address. A one-cycle read strobe marks each completed host read. The response is registered, so it appears on the clock edge that samples the strobe and then holds.

Top module: `pollresp`

## Requirements
- R1: While busy, a read of the last loaded address returns the inverse of bit 7 of the last loaded byte on data bit 7.
- R2: While busy, data bit 6 of the first read of a busy period is 0 and alternates 0,1,0,... on each further read strobe.
- R3: While busy is low, a read returns all eight bits of the array data presented with the strobe.
- R4: While busy, data bits 5..0 of a read equal bits 5..0 of the last loaded byte.
- R5: Polling reads may begin at any cycle of a busy period, including the cycle in which busy rises and cycles well after it.
- R6: The toggle advances only on cycles that carry a read strobe while busy; idle cycles and reads while not busy leave it unchanged.
- R7: The read data register resets to 0x00. It loads on the rising clock edge that samples a read strobe and holds its value otherwise.
- R8: The toggle is cleared to 0 when busy rises, even if no read occurs in that cycle.
- R9: With STRICT_ADDR=1 (default), a busy read at an address other than the last loaded address returns the true bit 7 of the last loaded byte. With STRICT_ADDR=0, every busy read inverts bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Program or dummy busy period in progress |
| last_data | input | 8 | Last byte loaded by the write sequencer |
| last_addr | input | AW | Address of the last loaded byte |
| rd_strobe | input | 1 | One-cycle pulse per completed host read |
| rd_addr | input | AW | Host read address |
| arr_data | input | 8 | Array data for rd_addr |
| rd_data | output | 8 | Registered read data returned to the host |

## Verification
A scripted run steps through idle reads, entry into busy with a read in the rising cycle, consecutive busy reads, and a return to idle. Its last-loaded bytes differ in bits 7 and 6, which separates a wrong inversion from a wrong toggle. Directed cases let busy rise with the toggle left at 1, then insert idle cycles before the first read. This tells a correct clear at cycle start apart from a clear done on read, and a strobe-driven toggle apart from a clock-driven one. A strict and a non-strict instance read the same mismatching address, which exposes the address qualification of bit 7.

// File: rtl/pollresp_pkg.sv
package pollresp_pkg;
  typedef logic [7:0] rbyte_t;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned ECHO_W   = TOG_BIT;
endpackage

// File: rtl/pollresp_rst_sync.sv
module pollresp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/pollresp_start_det.sv
module pollresp_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic start
);
  logic busy_q;
  logic busy_d;

  always_comb begin
    busy_d = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign start = busy & ~busy_q;
endmodule

// File: rtl/pollresp_toggle.sv
module pollresp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic start,
  input  logic rd_strobe,
  output logic tog_rd
);
  logic tog_q;
  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_en = start | (rd_strobe & busy);
    tog_rd = start ? 1'b0 : tog_q;
    tog_d  = tog_q;
    if (start)  tog_d = rd_strobe;
    else if (tog_en) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  // R2
  flip_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy && !start) |=> (tog_q != $past(tog_q)));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(rd_strobe && busy)) |=> $stable(tog_q));

  // R8
  clear_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_strobe) |=> !tog_q);
endmodule

// File: rtl/pollresp_mux.sv
module pollresp_mux
  import pollresp_pkg::*;
#(
  parameter int unsigned AW          = 19,
  parameter bit          STRICT_ADDR = 1'b1
) (
  input  logic          busy,
  input  logic          tog,
  input  rbyte_t        last_data,
  input  logic [AW-1:0] last_addr,
  input  logic [AW-1:0] rd_addr,
  input  rbyte_t        arr_data,
  output rbyte_t        resp
);
  logic addr_hit;

  generate
    if (STRICT_ADDR) begin : g_strict
      assign addr_hit = (rd_addr == last_addr);
    end else begin : g_any
      logic [AW-1:0] addr_unused;
      assign addr_unused = rd_addr ^ last_addr;
      assign addr_hit = 1'b1 | (&addr_unused);
    end
  endgenerate

  always_comb begin
    if (busy) begin
      resp[POLL_BIT]   = last_data[POLL_BIT] ^ addr_hit;
      resp[TOG_BIT]    = tog;
      resp[ECHO_W-1:0] = last_data[ECHO_W-1:0];
    end else begin
      resp = arr_data;
    end
  end
endmodule

// File: rtl/pollresp.sv
module pollresp
  import pollresp_pkg::*;
#(
  parameter int unsigned AW          = 19,
  parameter bit          STRICT_ADDR = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [7:0]    last_data,
  input  logic [AW-1:0] last_addr,
  input  logic          rd_strobe,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_data,
  output logic [7:0]    rd_data
);
  logic   rst_n_s;
  logic   start;
  logic   tog_rd;
  rbyte_t resp;
  rbyte_t rd_q;
  rbyte_t rd_d;

  pollresp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  pollresp_start_det u_start (
    .clk(clk), .rst_n(rst_n_s), .busy(busy), .start(start));

  pollresp_toggle u_tog (
    .clk(clk), .rst_n(rst_n_s), .busy(busy), .start(start),
    .rd_strobe(rd_strobe), .tog_rd(tog_rd));

  pollresp_mux #(.AW(AW), .STRICT_ADDR(STRICT_ADDR)) u_mux (
    .busy(busy), .tog(tog_rd), .last_data(last_data),
    .last_addr(last_addr), .rd_addr(rd_addr), .arr_data(arr_data),
    .resp(resp));

  always_comb begin
    rd_d = rd_strobe ? resp : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       rd_q <= '0;
    else if (rd_strobe) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R1
  poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_strobe && busy && rd_addr == last_addr) |=>
      (rd_data[7] != $past(last_data[7])));

  // R3
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_strobe && !busy) |=> (rd_data == $past(arr_data)));

  // R4
  echo_low_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_strobe && busy) |=> (rd_data[5:0] == $past(last_data[5:0])));

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_strobe |=> $stable(rd_data));
endmodule

// File: tb/pollresp_bench.sv
`timescale 1ns/1ps
module pollresp_bench;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          busy;
  logic [7:0]    last_data;
  logic [AW-1:0] last_addr;
  logic          rd_strobe;
  logic [AW-1:0] rd_addr;
  logic [7:0]    arr_data;
  logic [7:0]    rd_data;
  logic [7:0]    rd_data_any;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pollresp #(.AW(AW)) u_pollresp (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_data(last_data),
    .last_addr(last_addr), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .arr_data(arr_data), .rd_data(rd_data));

  pollresp #(.AW(AW), .STRICT_ADDR(1'b0)) u_pollresp_any (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_data(last_data),
    .last_addr(last_addr), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .arr_data(arr_data), .rd_data(rd_data_any));

  // {busy, last_data, arr_data, expected}
  localparam logic [24:0] VEC [9] = '{
    {1'b0, 8'h00, 8'h5A, 8'h5A},
    {1'b1, 8'hA5, 8'hFF, 8'h25},
    {1'b1, 8'hA5, 8'h00, 8'h65},
    {1'b1, 8'hA5, 8'h00, 8'h25},
    {1'b0, 8'hA5, 8'h3C, 8'h3C},
    {1'b0, 8'hA5, 8'hC3, 8'hC3},
    {1'b1, 8'h7E, 8'h00, 8'hBE},
    {1'b1, 8'h7E, 8'h00, 8'hFE},
    {1'b0, 8'h7E, 8'h81, 8'h81}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] arr);
    rd_addr   = a;
    arr_data  = arr;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; busy = 1'b0; last_data = '0; last_addr = '0;
    rd_strobe = 1'b0; rd_addr = '0; arr_data = 8'hEE;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check("R7 reset value", rd_data, 8'h00);

    // Scripted walk (R1 R2 R3 R4 R5)
    for (int v = 0; v < 9; v++) begin
      busy      = VEC[v][24];
      last_data = VEC[v][23:16];
      last_addr = '0;
      do_read('0, VEC[v][15:8]);
      check($sformatf("R1/R2/R3/R4 vector %0d", v), rd_data, VEC[v][7:0]);
      check($sformatf("R1/R2/R3/R4 vector %0d (any)", v), rd_data_any, VEC[v][7:0]);
      idle(1);
    end

    // R7: hold with no strobe while arr_data changes
    arr_data = 8'h11;
    idle(5);
    check("R7 hold", rd_data, 8'h81);

    // R8: toggle left at 1, new busy period, no read at rise
    busy = 1'b1; last_data = 8'h00;
    do_read('0, 8'h00);               // bit6 0, toggle -> 1
    check("R2 first read", rd_data, 8'h80);
    busy = 1'b0;
    do_read('0, 8'h42);
    check("R3 after busy", rd_data, 8'h42);
    busy = 1'b1;
    idle(6);                          // R5/R6: late start, idle cycles
    do_read('0, 8'h00);
    check("R8 cleared at rise", rd_data, 8'h80);
    idle(7);
    do_read('0, 8'h00);
    check("R6 idle does not advance", rd_data, 8'hC0);

    // R6: reads while idle leave toggle; R8 clears it anyway at next rise
    busy = 1'b0;
    do_read('0, 8'h00);
    do_read('0, 8'h00);
    busy = 1'b1;
    do_read('0, 8'h00);
    check("R5 read in rising cycle", rd_data, 8'h80);

    // R9: address qualification of bit 7
    busy = 1'b0; idle(2);
    busy = 1'b1; last_data = 8'h80; last_addr = 19'h00123;
    do_read(19'h00124, 8'h00);
    check("R9 strict mismatch", rd_data, 8'h80);
    check("R9 any-address mismatch", rd_data_any, 8'h00);
    do_read(19'h00123, 8'h00);
    check("R9 strict match", rd_data, 8'h40);
    check("R9 any-address match", rd_data_any, 8'h40);
    busy = 1'b0;
    do_read(19'h00123, 8'h9D);
    check("R3 true data after cycle", rd_data, 8'h9D);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule